// File: doc/BRIEF.md
# Protection-Entry Configuration Register with Write Filtering

This block is a machine-level control register. It holds one 8-bit configuration byte for each entry in a group of physical-memory-protection entries. It answers CSR requests at address 0x3aa. A request carries an address, a write strobe, write data and the current privilege level. The block returns read data and an illegal-access flag. The register is 32 bits wide or 64 bits wide, as selected by a base-width input.

Every byte is filtered on its own before it is stored. A byte that would be illegal is refused as a whole and keeps its previous value; it is never partly corrected. Three things can refuse a write to a byte:
- the byte is already locked;
- the new byte asks for write permission without read permission;
- the new byte selects the four-byte naturally-aligned mode while the granularity parameter is 2 or more.

Bytes for entries that are not implemented are fixed at zero. The stored lock, address-mode and permission bits are exported to a downstream region checker.

Top module: `pmp_cfg_csr`

## Requirements
- R1: After reset, every implemented byte is 0x00, which means unlocked with mode OFF. All exports read zero, and a machine-level read returns zero.
- R2: A machine-level write to address 0x3aa stores each legal byte. A machine-level read returns the stored bytes in the same cycle. Entry 40+i is held in byte i, which is bits 8i+7 to 8i.
- R3: Bits 6:5 of every byte are reserved. They are always stored and read as 0, whatever value is written.
- R4: A byte whose stored lock bit (bit 7) is 1 ignores every write. Only reset clears it.
- R5: A new byte with R=0 (bit 0) and W=1 (bit 1) is refused, and that byte keeps its old value.
- R6: When the parameter GRAN is 2 or more, a new byte whose mode field (bits 4:3) is 2 is refused. When GRAN is below 2, mode 2 is accepted. The mode codes are OFF=0, TOR=1, NA4=2 and NAPOT=3.
- R7: A byte whose entry index 40+i is NUM_ENTRIES or above always reads 0. Its exports are also 0.
- R8: When wide_mode is 0, only bytes 0 to 3 are visible. Writes leave bytes 4 to 7 unchanged, and read data bits 63:32 are zero. When wide_mode is 1, all 8 bytes are visible.
- R9: Each byte is filtered independently. In a single write, some bytes can update while others keep their old value.
- R10: If an access to 0x3aa comes from a privilege level below machine level (csr_priv other than 3), csr_illegal is raised in the same cycle. No byte changes, and the read data is zero.
- R11: The exports show each stored byte as follows: ent_lock[i] is bit 7, ent_amode[2i+1:2i] is bits 4:3, and ent_perm[3i+2:3i] is bits {X,W,R} = bits 2:0.
- R12: An access to any other address changes nothing. It reads zero and does not raise csr_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_req | input | 1 | A CSR access is presented this cycle |
| csr_we | input | 1 | The access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data |
| csr_priv | input | 2 | Current privilege level (3 = machine) |
| wide_mode | input | 1 | 0 = 32-bit register view, 1 = 64-bit view |
| csr_rdata | output | 64 | Read data, combinational |
| csr_illegal | output | 1 | Access attempted below machine level |
| ent_lock | output | 8 | Per-entry lock bit |
| ent_amode | output | 16 | Per-entry address mode, 2 bits each |
| ent_perm | output | 24 | Per-entry {X,W,R}, 3 bits each |

## Verification
The bench builds two instances that share the same stimulus.

The first instance, `dut`, uses NUM_ENTRIES=46 and GRAN=2. In this instance bytes 6 and 7 are unimplemented, so the fixed-zero bytes can be seen at the top of the 64-bit view. This instance also refuses the four-byte mode.

The second instance, `dut_fine`, uses NUM_ENTRIES=48 and GRAN=0. It implements all eight bytes and accepts mode 2. The same NA4 write can therefore be checked as refused in one instance and accepted in the other.

// File: rtl/pmpcfg_pkg.sv
// Package: shared types for the protection-entry configuration register.
// Assumes each configuration byte uses the fixed layout below, which the region checker decodes.
package pmpcfg_pkg;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic       lock;   // bit 7
        logic [1:0] rsv;    // bits 6:5
        amode_e     amode;  // bits 4:3
        logic       x;      // bit 2
        logic       w;      // bit 1
        logic       r;      // bit 0
    } cfg_byte_t;

endpackage

// File: rtl/pmp_cfg_legalize.sv
// Module: decides whether one proposed configuration byte may replace the current one.
// Assumes the caller writes the byte only when ok is high. The clean value has its reserved bits cleared.
module pmp_cfg_legalize
    import pmpcfg_pkg::*;
#(
    parameter int GRAN = 2
) (
    input  cfg_byte_t cur,
    input  cfg_byte_t nxt,
    output logic      ok,
    output cfg_byte_t clean
);

    logic wo_combo;
    logic na4_banned;

    // Flag the write-without-read permission pair and the coarse-grain NA4 selection
    always_comb begin
        wo_combo   = nxt.w && !nxt.r;
        na4_banned = (GRAN >= 2) && (nxt.amode == AM_NA4);
        ok         = !cur.lock && !wo_combo && !na4_banned;
        clean      = nxt;
        clean.rsv  = 2'b00;
    end

endmodule

// File: rtl/pmp_cfg_entry.sv
// Module: storage for one implemented configuration byte, with the write filter in front of it.
// Assumes wr_req is already qualified by address, privilege and the width view.
module pmp_cfg_entry
    import pmpcfg_pkg::*;
#(
    parameter int GRAN = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_req,
    input  cfg_byte_t wdata,
    output cfg_byte_t q
);

    logic      ok;
    cfg_byte_t clean;

    pmp_cfg_legalize #(.GRAN(GRAN)) u_legal (
        .cur   (q),
        .nxt   (wdata),
        .ok    (ok),
        .clean (clean)
    );

    // Hold the byte; clear it on reset and load only legal values
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_req && ok)
            q <= clean;
    end

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> $stable(q));

    // R5
    no_wo_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.w && !q.r));

    generate
        if (GRAN >= 2) begin : g_na4
            // R6
            no_na4_chk: assert property (@(posedge clk) disable iff (!rst_n)
                q.amode != AM_NA4);
        end
    endgenerate

endmodule

// File: rtl/pmp_cfg_csr.sv
// Module: machine-level configuration register for eight protection entries starting at BASE_ENTRY.
// Assumes a single-cycle CSR request with combinational read data. Writes take effect at the next clock edge.
module pmp_cfg_csr
    import pmpcfg_pkg::*;
#(
    parameter int                NUM_ENTRIES = 46,
    parameter int                GRAN        = 2,
    parameter int                BASE_ENTRY  = 40,
    parameter int                MAX_XLEN    = 64,
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR    = 12'h3AA
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     csr_req,
    input  logic                     csr_we,
    input  logic [ADDR_W-1:0]        csr_addr,
    input  logic [MAX_XLEN-1:0]      csr_wdata,
    input  logic [1:0]               csr_priv,
    input  logic                     wide_mode,
    output logic [MAX_XLEN-1:0]      csr_rdata,
    output logic                     csr_illegal,
    output logic [MAX_XLEN/8-1:0]    ent_lock,
    output logic [2*MAX_XLEN/8-1:0]  ent_amode,
    output logic [3*MAX_XLEN/8-1:0]  ent_perm
);

    localparam int NB        = MAX_XLEN / 8;
    localparam int NB_NARROW = NB / 2;

    logic                hit;
    logic                is_m;
    logic                acc_ok;
    logic                wr_go;
    logic [NB-1:0][7:0]  cfg_q;

    // Decode address match and privilege for this request
    always_comb begin
        hit         = csr_req && (csr_addr == CSR_ADDR);
        is_m        = (csr_priv == PRIV_MACHINE);
        acc_ok      = hit && is_m;
        wr_go       = acc_ok && csr_we;
        csr_illegal = hit && !is_m;
    end

    generate
        for (genvar i = 0; i < NB; i++) begin : g_byte
            localparam int IDX = BASE_ENTRY + i;
            if (IDX < NUM_ENTRIES) begin : g_impl
                cfg_byte_t q_b;
                logic      in_view;
                assign in_view = wide_mode || (i < NB_NARROW);
                pmp_cfg_entry #(.GRAN(GRAN)) u_entry (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .wr_req (wr_go && in_view),
                    .wdata  (cfg_byte_t'(csr_wdata[8*i +: 8])),
                    .q      (q_b)
                );
                assign cfg_q[i] = q_b;
            end else begin : g_zero
                assign cfg_q[i] = 8'h00;
                // R7
                unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (csr_rdata[8*i +: 8] == 8'h00) && !ent_lock[i] && (ent_perm[3*i +: 3] == 3'b000));
            end
        end
    endgenerate

    // Assemble read data from the visible bytes of a permitted access
    always_comb begin
        csr_rdata = '0;
        if (acc_ok) begin
            for (int i = 0; i < NB; i++) begin
                if (wide_mode || (i < NB_NARROW))
                    csr_rdata[8*i +: 8] = cfg_q[i];
            end
        end
    end

    // Split the stored bytes into the fields the region checker needs
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            ent_lock[i]          = cfg_q[i][7];
            ent_amode[2*i +: 2]  = cfg_q[i][4:3];
            ent_perm[3*i +: 3]   = cfg_q[i][2:0];
        end
    end

    // R10
    priv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && (csr_addr == CSR_ADDR) && (csr_priv != PRIV_MACHINE)) |=> $stable(cfg_q));

    // R8
    narrow_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (csr_rdata[MAX_XLEN-1:MAX_XLEN/2] == '0));

    // R8
    narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |=> $stable(cfg_q[NB-1:NB_NARROW]));

endmodule

// File: tb/tb_pmp_cfg_csr.sv
`timescale 1ns/1ps
module tb_pmp_cfg_csr;

    localparam int N0 = 46, G0 = 2;
    localparam int N1 = 48, G1 = 0;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        csr_req = 0, csr_we = 0, wide_mode = 1;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [1:0]  csr_priv = 2'b11;

    logic [63:0] rd0, rd1;
    logic        il0, il1;
    logic [7:0]  lk0, lk1;
    logic [15:0] am0, am1;
    logic [23:0] pm0, pm1;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] m0 [8];
    logic [7:0] m1 [8];

    always #4 clk = ~clk;

    pmp_cfg_csr #(.NUM_ENTRIES(N0), .GRAN(G0)) dut (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_priv(csr_priv), .wide_mode(wide_mode),
        .csr_rdata(rd0), .csr_illegal(il0), .ent_lock(lk0), .ent_amode(am0), .ent_perm(pm0));

    pmp_cfg_csr #(.NUM_ENTRIES(N1), .GRAN(G1)) dut_fine (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_priv(csr_priv), .wide_mode(wide_mode),
        .csr_rdata(rd1), .csr_illegal(il1), .ent_lock(lk1), .ent_amode(am1), .ent_perm(pm1));

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_rd(input int n, input logic [7:0] m [8]);
        logic [63:0] v = '0;
        if (csr_req && csr_addr == 12'h3AA && csr_priv == 2'b11)
            for (int i = 0; i < 8; i++)
                if ((wide_mode || i < 4) && (40 + i < n)) v[8*i +: 8] = m[i];
        return v;
    endfunction

    // Compare every output of both instances with the reference model
    task automatic compare(input string tag);
        logic [7:0]  el0, el1;
        logic [15:0] ea0, ea1;
        logic [23:0] ep0, ep1;
        logic        eil;
        eil = csr_req && csr_addr == 12'h3AA && csr_priv != 2'b11;
        for (int i = 0; i < 8; i++) begin
            el0[i] = m0[i][7]; ea0[2*i +: 2] = m0[i][4:3]; ep0[3*i +: 3] = m0[i][2:0];
            el1[i] = m1[i][7]; ea1[2*i +: 2] = m1[i][4:3]; ep1[3*i +: 3] = m1[i][2:0];
        end
        chk(tag, "dut rdata",      rd0, exp_rd(N0, m0));
        chk(tag, "dut_fine rdata", rd1, exp_rd(N1, m1));
        chk(tag, "dut illegal",    64'(il0), 64'(eil));
        chk(tag, "dut_fine illegal", 64'(il1), 64'(eil));
        chk({tag, " R11"}, "dut exports",      {lk0, am0, pm0}, {el0, ea0, ep0});
        chk({tag, " R11"}, "dut_fine exports", {lk1, am1, pm1}, {el1, ea1, ep1});
    endtask

    // Apply one write to a model copy according to the requirements
    task automatic model_write(input int n, input int g, ref logic [7:0] m [8]);
        if (!(csr_req && csr_we && csr_addr == 12'h3AA && csr_priv == 2'b11)) return;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] nb;
            nb = csr_wdata[8*i +: 8];
            if ((40 + i < n) && (wide_mode || i < 4) && !m[i][7] &&
                !(nb[1] && !nb[0]) && !(g >= 2 && nb[4:3] == 2'd2))
                m[i] = nb & 8'h9F;
        end
    endtask

    task automatic op(input string tag, input logic we, input logic [11:0] a,
                      input logic [63:0] d, input logic [1:0] p, input logic wm);
        @(negedge clk);
        csr_req = 1; csr_we = we; csr_addr = a; csr_wdata = d; csr_priv = p; wide_mode = wm;
        #1 compare(tag);
        @(posedge clk);
        model_write(N0, G0, m0);
        model_write(N1, G1, m1);
    endtask

    task automatic rd(input string tag, input logic wm);
        op(tag, 0, 12'h3AA, 64'h0, 2'b11, wm);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m0[i] = 8'h00; m1[i] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        rd("R1 reset", 1);
        // R2 and R7: write every byte with a legal TOR RWX pattern
        op("R2 R7 write", 1, 12'h3AA, 64'h0F0F0F0F_0F0F0F0F, 2'b11, 1);
        rd("R2 R7 readback", 1);
        // R3: reserved bits set on write
        op("R3 reserved", 1, 12'h3AA, 64'h67676767_67676767, 2'b11, 1);
        rd("R3 readback", 1);
        // R5 and R9: byte 0 write-only, the rest legal
        op("R5 R9 write", 1, 12'h3AA, 64'h1B1B1B1B_1B1B1B02, 2'b11, 1);
        rd("R5 R9 readback", 1);
        // R6: byte 1 selects NA4
        op("R6 na4", 1, 12'h3AA, 64'h0B0B0B0B_0B0B110B, 2'b11, 1);
        rd("R6 readback", 1);
        // R4: lock byte 2, then try to change it
        op("R4 lock", 1, 12'h3AA, 64'h0B0B0B0B_0B810B0B, 2'b11, 1);
        op("R4 overwrite", 1, 12'h3AA, 64'h00000000_00000000, 2'b11, 1);
        rd("R4 readback", 1);
        // R8: narrow view write and read
        op("R8 narrow write", 1, 12'h3AA, 64'h1F1F1F1F_05050505, 2'b11, 0);
        rd("R8 narrow read", 0);
        rd("R8 wide read", 1);
        // R10: supervisor and user attempts
        op("R10 sup write", 1, 12'h3AA, 64'h01010101_01010101, 2'b01, 1);
        op("R10 user read", 0, 12'h3AA, 64'h0, 2'b00, 1);
        rd("R10 readback", 1);
        // R12: other address
        op("R12 other addr", 1, 12'h3AB, 64'h01010101_01010101, 2'b11, 1);
        op("R12 other addr user", 1, 12'h3A0, 64'h01010101_01010101, 2'b00, 1);
        rd("R12 readback", 1);
        // R1: reset clears locks too
        @(negedge clk) rst_n = 0; csr_req = 0;
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin m0[i] = 8'h00; m1[i] = 8'h00; end
        @(negedge clk) rst_n = 1;
        rd("R1 re-reset", 1);
        op("R4 R1 unlocked after reset", 1, 12'h3AA, 64'h09090909_09090909, 2'b11, 1);
        rd("R4 R1 readback", 1);
        @(negedge clk) csr_req = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule